// File: doc/BRIEF.md
# Double-Error-Correcting Binary BCH Decoder (63/51)

This block takes a 63-bit received word from a binary cyclic code with 51 message bits and 12 parity bits. It repairs up to two flipped bits and returns the 51 message bits together with the number of bits it repaired. If the word lies farther than two bit flips from every codeword, the block raises a failure flag instead. Words arrive through a valid/ready handshake and are decoded one at a time. A one-cycle done pulse marks each result.

Decoding is a fixed chain of three stages. First, two odd syndromes are evaluated over GF(2^6) with the field polynomial x^6+x+1. Second, two iterations of an inversion-free Berlekamp-Massey update produce an error-locator polynomial of degree at most two. The even iterations are skipped because the code is binary, and no field inverse or division is used anywhere. Third, a serial Chien search tests one bit position per clock and flips each position where the locator evaluates to zero. A word whose syndromes are both zero skips the last two stages.

Bit i of `in_word` is the coefficient of x^i. The code's generator polynomial is (x^6+x+1)(x^6+x^4+x^2+x+1). The encoder is systematic, so the message occupies bits 62..12 and the parity occupies bits 11..0.

Top module: `bch2_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `in_ready` is 1, `out_done` is 0, and `out_msg`, `out_nerr` and `out_fail` are 0.
- R2: A word is taken only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the done pulse. Words offered while `in_ready` is 0 are ignored and do not change the result.
- R3: If the received word is a codeword, `out_done` rises two clock edges after the accepting edge, with `out_nerr`=0, `out_fail`=0 and `out_msg` = received bits 62..12.
- R4: A word with exactly one flipped bit, at any position 0..62, is repaired: `out_msg` equals the original message, `out_nerr`=1 and `out_fail`=0.
- R5: A word with exactly two flipped bits is repaired, with `out_nerr`=2 and `out_fail`=0. This holds when both flips fall in the parity bits 11..0 and when they straddle bits 11 and 12.
- R6: A word that is more than two flips away from every codeword gives `out_fail`=1, `out_nerr`=0 and `out_msg` = received bits 62..12 unmodified.
- R7: If the received word is not a codeword, `out_done` rises exactly 66 clock edges after the accepting edge (2 syndrome/locator edges, then 63 search edges, then 1 more).
- R8: `out_done` is high for exactly one cycle per accepted word. `out_msg`, `out_nerr` and `out_fail` hold their values in every cycle that `out_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received word is offered |
| in_ready | output | 1 | The decoder is idle and takes a word |
| in_word | input | 63 | Received word; bit i is the coefficient of x^i |
| out_done | output | 1 | One-cycle pulse: the outputs carry a new result |
| out_msg | output | 51 | Repaired message bits (or raw bits 62..12 on failure) |
| out_nerr | output | 2 | Number of bits repaired (0, 1 or 2) |
| out_fail | output | 1 | The word could not be repaired |

## Verification
The result for a codeword is due two clock edges after the accepting edge. The result for any other word is due at the 66th edge. The bench counts rising edges from the accepting edge and samples `out_done` on the following falling edge, so an early or late pulse fails the latency check of R3 or R7. Each expected result comes from a brute-force reference that tries every pattern of up to two bit flips and tests the result by polynomial division. One cycle after each pulse, the bench checks that done has dropped and that the outputs have held.

// File: rtl/bch2_pkg.sv
package bch2_pkg;

    localparam int GF_M    = 6;
    localparam int CW_LEN  = (1 << GF_M) - 1;
    localparam int MSG_LEN = 51;
    localparam int PAR_LEN = CW_LEN - MSG_LEN;
    localparam int IDX_W   = $clog2(CW_LEN);
    localparam logic [GF_M:0] FIELD_POLY = 7'b1000011;

    typedef logic [GF_M-1:0] gf_t;

    // locator polynomial, degree at most two
    typedef struct packed {
        gf_t c2;
        gf_t c1;
        gf_t c0;
    } poly2_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYND,
        ST_KEY1,
        ST_KEY2,
        ST_SRCH
    } dec_state_t;

    function automatic gf_t gf_mulx(input gf_t a);
        gf_t r;
        r = {a[GF_M-2:0], 1'b0};
        if (a[GF_M-1]) r = r ^ FIELD_POLY[GF_M-1:0];
        return r;
    endfunction

    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_t p;
        p = '0;
        for (int k = GF_M - 1; k >= 0; k--) begin
            p = gf_mulx(p);
            if (b[k]) p = p ^ a;
        end
        return p;
    endfunction

    function automatic gf_t gf_pow(input int e);
        gf_t p;
        p = gf_t'(1);
        for (int k = 0; k < CW_LEN; k++) begin
            if (k < e) p = gf_mulx(p);
        end
        return p;
    endfunction

    function automatic logic [1:0] poly_deg(input poly2_t p);
        if (p.c2 != '0) return 2'd2;
        if (p.c1 != '0) return 2'd1;
        return 2'd0;
    endfunction

endpackage

// File: rtl/bch2_syndrome.sv
module bch2_syndrome
    import bch2_pkg::*;
(
    input  logic [CW_LEN-1:0] word,
    output gf_t               s1,
    output gf_t               s3
);

    gf_t term1 [CW_LEN];
    gf_t term3 [CW_LEN];

    for (genvar i = 0; i < CW_LEN; i++) begin : g_pos
        localparam gf_t ROOT1 = gf_pow(i);
        localparam gf_t ROOT3 = gf_pow((3 * i) % CW_LEN);
        assign term1[i] = word[i] ? ROOT1 : '0;
        assign term3[i] = word[i] ? ROOT3 : '0;
    end

    always_comb begin
        s1 = '0;
        s3 = '0;
        for (int i = 0; i < CW_LEN; i++) begin
            s1 = s1 ^ term1[i];
            s3 = s3 ^ term3[i];
        end
    end

endmodule

// File: rtl/bch2_berlekamp.sv
module bch2_berlekamp
    import bch2_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   first,
    input  logic   second,
    input  gf_t    s1,
    input  gf_t    s3,
    output poly2_t lam_upd
);

    localparam poly2_t UNIT = '{c2: '0, c1: '0, c0: gf_t'(1)};

    poly2_t            lam_q, b_q;
    gf_t               gam_q;
    logic signed [3:0] k_q;

    poly2_t            src_lam, src_b, base, b_nxt;
    gf_t               src_gam, s2, disc, syn_a, syn_b, syn_c;
    logic signed [3:0] src_k, k_nxt;
    logic              taken;

    always_comb begin
        src_lam = first ? UNIT : lam_q;
        src_b   = first ? UNIT : b_q;
        src_gam = first ? gf_t'(1) : gam_q;
        src_k   = first ? 4'sd0 : k_q;
        s2      = gf_mul(s1, s1);
        syn_a   = first ? s1 : s3;
        syn_b   = first ? gf_t'(0) : s2;
        syn_c   = first ? gf_t'(0) : s1;

        disc = gf_mul(src_lam.c0, syn_a) ^ gf_mul(src_lam.c1, syn_b)
             ^ gf_mul(src_lam.c2, syn_c);

        // scaled update: gamma * lambda + disc * x * b
        lam_upd.c0 = gf_mul(src_gam, src_lam.c0);
        lam_upd.c1 = gf_mul(src_gam, src_lam.c1) ^ gf_mul(disc, src_b.c0);
        lam_upd.c2 = gf_mul(src_gam, src_lam.c2) ^ gf_mul(disc, src_b.c1);

        taken = (disc != '0) && (src_k >= 0);
        base  = taken ? src_lam : src_b;
        b_nxt = '{c2: base.c1, c1: base.c0, c0: '0};
        k_nxt = taken ? (-src_k - 4'sd1) : (src_k + 4'sd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lam_q <= UNIT;
            b_q   <= UNIT;
            gam_q <= gf_t'(1);
            k_q   <= 4'sd0;
        end else if (first || second) begin
            lam_q <= lam_upd;
            b_q   <= b_nxt;
            gam_q <= taken ? disc : src_gam;
            k_q   <= k_nxt;
        end
    end

endmodule

// File: rtl/bch2_chien.sv
module bch2_chien
    import bch2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  poly2_t            lam_in,
    output logic              last,
    output logic [CW_LEN-1:0] mask_fin,
    output logic [1:0]        cnt_fin
);

    localparam gf_t STEP1 = gf_pow(CW_LEN - 1);
    localparam gf_t STEP2 = gf_pow(CW_LEN - 2);

    gf_t               l0_q, t1_q, t2_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CW_LEN-1:0] mask_q;
    logic [1:0]        cnt_q;
    logic              hit;

    always_comb begin
        hit      = (l0_q ^ t1_q ^ t2_q) == '0;
        mask_fin = mask_q | ({{(CW_LEN-1){1'b0}}, hit} << idx_q);
        cnt_fin  = cnt_q + {1'b0, hit};
        last     = idx_q == IDX_W'(CW_LEN - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l0_q   <= '0;
            t1_q   <= '0;
            t2_q   <= '0;
            idx_q  <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            l0_q   <= lam_in.c0;
            t1_q   <= lam_in.c1;
            t2_q   <= lam_in.c2;
            idx_q  <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (step) begin
            t1_q   <= gf_mul(t1_q, STEP1);
            t2_q   <= gf_mul(t2_q, STEP2);
            idx_q  <= idx_q + 1'b1;
            mask_q <= mask_fin;
            cnt_q  <= cnt_fin;
        end
    end

endmodule

// File: rtl/bch2_decoder.sv
module bch2_decoder
    import bch2_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CW_LEN-1:0]  in_word,
    output logic               out_done,
    output logic [MSG_LEN-1:0] out_msg,
    output logic [1:0]         out_nerr,
    output logic               out_fail
);

    dec_state_t        state_q;
    logic [CW_LEN-1:0] word_q;
    gf_t               s1_c, s3_c, s1_q, s3_q;
    poly2_t            lam_upd;
    logic [1:0]        deg_q;
    logic              last;
    logic [CW_LEN-1:0] mask_fin;
    logic [1:0]        cnt_fin;
    logic [CW_LEN-1:0] fixed;
    logic              bad;

    bch2_syndrome u_syn (
        .word (word_q),
        .s1   (s1_c),
        .s3   (s3_c)
    );

    bch2_berlekamp u_bm (
        .clk     (clk),
        .rst     (rst),
        .first   (state_q == ST_KEY1 && (s1_q != '0 || s3_q != '0)),
        .second  (state_q == ST_KEY2),
        .s1      (s1_q),
        .s3      (s3_q),
        .lam_upd (lam_upd)
    );

    bch2_chien u_chien (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_KEY2),
        .step     (state_q == ST_SRCH),
        .lam_in   (lam_upd),
        .last     (last),
        .mask_fin (mask_fin),
        .cnt_fin  (cnt_fin)
    );

    assign in_ready = state_q == ST_IDLE;
    assign fixed    = word_q ^ mask_fin;
    assign bad      = cnt_fin != deg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            word_q   <= '0;
            s1_q     <= '0;
            s3_q     <= '0;
            deg_q    <= '0;
            out_done <= 1'b0;
            out_msg  <= '0;
            out_nerr <= '0;
            out_fail <= 1'b0;
        end else begin
            out_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        word_q  <= in_word;
                        state_q <= ST_SYND;
                    end
                end
                ST_SYND: begin
                    s1_q    <= s1_c;
                    s3_q    <= s3_c;
                    state_q <= ST_KEY1;
                end
                ST_KEY1: begin
                    if (s1_q == '0 && s3_q == '0) begin
                        out_done <= 1'b1;
                        out_msg  <= word_q[CW_LEN-1:PAR_LEN];
                        out_nerr <= '0;
                        out_fail <= 1'b0;
                        state_q  <= ST_IDLE;
                    end else begin
                        state_q <= ST_KEY2;
                    end
                end
                ST_KEY2: begin
                    deg_q   <= poly_deg(lam_upd);
                    state_q <= ST_SRCH;
                end
                ST_SRCH: begin
                    if (last) begin
                        out_done <= 1'b1;
                        out_fail <= bad;
                        out_nerr <= bad ? 2'd0 : deg_q;
                        out_msg  <= bad ? word_q[CW_LEN-1:PAR_LEN]
                                        : fixed[CW_LEN-1:PAR_LEN];
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bch2_decoder_chk.sv
module bch2_decoder_chk
    import bch2_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_done,
    input logic [MSG_LEN-1:0] out_msg,
    input logic [1:0]         out_nerr,
    input logic               out_fail
);

    localparam int CLEAN_LAT = 2;
    localparam int FULL_LAT  = CW_LEN + 3;

    logic [6:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) lat_q <= 7'd127;
        else if (in_valid && in_ready) lat_q <= '0;
        else if (lat_q != 7'd127) lat_q <= lat_q + 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (in_ready && !out_done && !out_fail && out_nerr == 2'd0));

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_clean_result_r3: assert property (@(posedge clk) disable iff (rst)
        (out_done && lat_q == 7'(CLEAN_LAT)) |-> (out_nerr == 2'd0 && !out_fail));

    p_count_range_r4: assert property (@(posedge clk) disable iff (rst)
        out_done |-> out_nerr != 2'd3);

    p_fail_count_r6: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_fail) |-> out_nerr == 2'd0);

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (lat_q == 7'(CLEAN_LAT) || lat_q == 7'(FULL_LAT)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_msg) && $stable(out_nerr) && $stable(out_fail)));

endmodule

bind bch2_decoder bch2_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_done (out_done),
    .out_msg  (out_msg),
    .out_nerr (out_nerr),
    .out_fail (out_fail)
);

// File: tb/bch2_decoder_bench.sv
module bch2_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [62:0] in_word = '0;
    logic        out_done;
    logic [50:0] out_msg;
    logic [1:0]  out_nerr;
    logic        out_fail;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [12:0] gen_poly;

    always #10 clk = ~clk;

    bch2_decoder u_bch2_decoder (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_word  (in_word),
        .out_done (out_done),
        .out_msg  (out_msg),
        .out_nerr (out_nerr),
        .out_fail (out_fail)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] poly_rem(input logic [62:0] v);
        logic [62:0] r;
        r = v;
        for (int i = 62; i >= 12; i--) begin
            if (r[i]) r = r ^ (63'(gen_poly) << (i - 12));
        end
        return r[11:0];
    endfunction

    function automatic logic [62:0] encode(input logic [50:0] m);
        return {m, poly_rem({m, 12'b0})};
    endfunction

    // brute-force reference: search every pattern of up to two flips
    task automatic ref_decode(input logic [62:0] raw, output bit found,
                              output logic [1:0] nerr, output logic [62:0] cw);
        found = 1'b0;
        nerr  = 2'd0;
        cw    = raw;
        if (poly_rem(raw) == 12'd0) begin
            found = 1'b1;
            return;
        end
        for (int a = 0; a < 63; a++) begin
            logic [62:0] t;
            t = raw ^ (63'd1 << a);
            if (poly_rem(t) == 12'd0) begin
                found = 1'b1; nerr = 2'd1; cw = t;
                return;
            end
        end
        for (int a = 0; a < 63; a++) begin
            for (int b = a + 1; b < 63; b++) begin
                logic [62:0] t;
                t = raw ^ (63'd1 << a) ^ (63'd1 << b);
                if (poly_rem(t) == 12'd0) begin
                    found = 1'b1; nerr = 2'd2; cw = t;
                    return;
                end
            end
        end
    endtask

    task automatic run_word(input logic [62:0] raw, input bit junk, input string tag);
        bit          found;
        logic [1:0]  exp_nerr;
        logic [62:0] exp_cw;
        logic [50:0] exp_msg;
        int          exp_lat;
        int          lat;
        logic [50:0] held_msg;
        string       t;

        ref_decode(raw, found, exp_nerr, exp_cw);
        exp_msg = found ? exp_cw[62:12] : raw[62:12];
        exp_lat = (poly_rem(raw) == 12'd0) ? 2 : 66;
        t = found ? tag : "R6";

        @(negedge clk);
        in_valid = 1'b1;
        in_word  = raw;
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        in_valid = junk;
        in_word  = ~raw;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (junk && lat == 1)
                check(in_ready == 1'b0, "R2 busy not ready", 64'(in_ready), 64'd0);
            if (out_done || lat > 200) break;
        end
        in_valid = 1'b0;

        check(lat == exp_lat, (exp_lat == 2) ? "R3 latency" : "R7 latency",
              64'(lat), 64'(exp_lat));
        check(out_msg == exp_msg, {t, " msg"}, 64'(out_msg), 64'(exp_msg));
        check(out_nerr == (found ? exp_nerr : 2'd0), {t, " nerr"},
              64'(out_nerr), 64'(found ? exp_nerr : 2'd0));
        check(out_fail == !found, {t, " fail"}, 64'(out_fail), 64'(!found));
        if (junk) check(out_msg == exp_msg, "R2 ignored word", 64'(out_msg), 64'(exp_msg));

        held_msg = out_msg;
        @(posedge clk);
        @(negedge clk);
        check(out_done == 1'b0 && out_msg == held_msg, "R8 pulse and hold",
              {63'd0, out_done}, 64'd0);
    endtask

    function automatic logic [62:0] flips(input int n);
        logic [62:0] m;
        m = '0;
        while ($countones(m) < n) m[$urandom % 63] = 1'b1;
        return m;
    endfunction

    function automatic logic [50:0] rand_msg();
        return {$urandom, $urandom}[50:0];
    endfunction

    initial begin
        logic [62:0] cw;
        void'($urandom(32'h5EED_0042));
        gen_poly = '0;
        for (int i = 0; i < 7; i++)
            if (7'b1010111 >> i & 7'd1) gen_poly = gen_poly ^ (13'b1000011 << i);

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1 && out_done == 1'b0, "R1 during reset",
              {62'd0, in_ready, out_done}, 64'd2);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(in_ready && !out_done && !out_fail && out_nerr == 0 && out_msg == 0,
              "R1 after reset", 64'(out_msg), 64'd0);

        run_word(encode('0), 1'b0, "R3");
        run_word(encode('1), 1'b0, "R3");
        cw = encode(rand_msg());
        run_word(cw, 1'b1, "R3");
        run_word(cw ^ 63'd1, 1'b0, "R4");
        run_word(cw ^ (63'd1 << 62), 1'b0, "R4");
        run_word(cw ^ (63'd1 << 12), 1'b0, "R4");
        run_word(cw ^ 63'd1 ^ (63'd1 << 62), 1'b0, "R5");
        run_word(cw ^ (63'd1 << 3) ^ (63'd1 << 9), 1'b0, "R5");
        run_word(cw ^ (63'd1 << 11) ^ (63'd1 << 12), 1'b1, "R5");
        run_word(cw ^ 63'h7, 1'b0, "R6");
        run_word(cw ^ 63'hF0, 1'b0, "R6");

        for (int n = 0; n < 40; n++) begin
            int ne;
            string tg;
            ne = $urandom % 5;
            tg = (ne == 0) ? "R3" : (ne == 1) ? "R4" : (ne == 2) ? "R5" : "R6";
            run_word(encode(rand_msg()) ^ flips(ne), n[0], tg);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule